// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching translation descriptors from memory. A single-cycle start pulse hands it the virtual address, the upper bits of the translation table base and a flag that says whether fine second-level tables may be used. The walker then makes one or two 32-bit word reads on a request/acknowledge memory port. It ends by reporting the physical address, a page type code, the domain number, the cacheable/bufferable pair and the access-permission field, or a fault.

The first-level descriptor either maps a 1 MB section directly or points at a coarse or fine second-level table. A second-level descriptor maps a 64 KB, 4 KB or 1 KB page. Each size splices a different number of virtual address bits into the result and reports a permission field of a different width. The block does no TLB caching and no domain permission checking.

Top module: `ttw_walker`

## Requirements
- R1: The first read targets address {tbase_i[17:0], va_i[31:20], 2'b00}: the 18 table base bits sit at address bits [31:14] and VA[31:20] sits at bits [13:2].
- R2: First-level bits [1:0] select the descriptor kind: 0 fault, 1 coarse table, 2 section, 3 fine table. A value of 0 ends the walk with fault_o=1 after one read. On every fault, pa_o, ptype_o, cb_o and ap_o are all zero.
- R3: When fine_en_i was 0 at start, first-level kind 3 is a fault and no second read is made. When fine_en_i was 1, kind 3 leads to a second-level read.
- R4: domain_o always equals first-level descriptor bits [8:5], including on faults that arise at the second level.
- R5: A section ends after exactly one read. It gives pa_o = {desc[31:20], VA[19:0]}, cb_o = desc[3:2] and ap_o = {6'b0, desc[11:10]}.
- R6: For a coarse table, the second read targets {desc[31:10], VA[19:12], 2'b00}.
- R7: For a fine table, the second read targets {desc[31:12], VA[19:10], 2'b00}.
- R8: Second-level bits [1:0] decode as follows. 0 is a fault. 1 gives pa_o = {d[31:16], VA[15:0]}. 2 gives {d[31:12], VA[11:0]}. 3 gives {d[31:10], VA[9:0]}.
- R9: For second-level pages, cb_o = d[3:2]. ap_o = d[11:4] for 64 KB and 4 KB pages, and ap_o = {6'b0, d[5:4]} for 1 KB pages.
- R10: ptype_o is 0 for a section, 1 for 64 KB, 2 for 4 KB and 3 for 1 KB pages.
- R11: mem_req_o and mem_addr_o stay constant until mem_ack_i is seen. Read data is sampled only in the acknowledge cycle, and data present in other cycles has no effect.
- R12: busy_o is high from the cycle after an accepted start until the walk finishes. done_o is high for exactly one cycle, which follows the last acknowledge, and the results are valid in that cycle.
- R13: A start pulse while busy_o is high is ignored: the running walk completes with its original inputs and no further walk follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| va_i | input | 32 | Virtual address to translate |
| tbase_i | input | 18 | Translation table base, address bits [31:14] |
| fine_en_i | input | 1 | Fine second-level tables allowed |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read word address (byte address) |
| mem_ack_i | input | 1 | Memory acknowledge, data valid |
| mem_rdata_i | input | 32 | Memory read data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Translation fault |
| pa_o | output | 32 | Physical address |
| ptype_o | output | 2 | Page type code |
| domain_o | output | 4 | Domain number |
| cb_o | output | 2 | Cacheable/bufferable bits |
| ap_o | output | 8 | Access-permission field |

## Verification
The bench sweeps every first-level kind against every second-level kind. It does this with fine support both on and off, several virtual addresses chosen so that neighbouring splice fields differ, and acknowledge latencies of zero to two cycles. A design that spliced at the wrong bit boundary would show a corrupted physical address or read address for only one page size. One that ignored the fine-support flag would issue a second read instead of faulting. The bench also drives junk on the read data outside acknowledge cycles, so a walker that latched data early would report garbage. It raises start in the middle of a walk, so a walker that restarted would read the wrong first-level address or run a second walk.

// File: rtl/ttw_pkg.sv
package ttw_pkg;

    localparam int WORD_W    = 32;
    localparam int TB_LO     = 14;
    localparam int TB_W      = WORD_W - TB_LO;
    localparam int SEC_LO    = 20;
    localparam int COARSE_LO = 10;
    localparam int FINE_LO   = 12;
    localparam int DOM_W     = 4;
    localparam int AP_W      = 8;
    localparam int CB_W      = 2;
    localparam int L2_VA_W   = 16;

    typedef enum logic [1:0] {
        PG_SECTION = 2'd0,
        PG_LARGE   = 2'd1,
        PG_SMALL   = 2'd2,
        PG_TINY    = 2'd3
    } page_t;

    typedef enum logic [1:0] {
        DK_FAULT   = 2'd0,
        DK_COARSE  = 2'd1,
        DK_SECTION = 2'd2,
        DK_FINE    = 2'd3
    } l1_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_L1,
        ST_L2,
        ST_DONE
    } walk_st_t;

    typedef struct packed {
        logic              fault;
        logic [WORD_W-1:0] pa;
        page_t             ptype;
        logic [DOM_W-1:0]  dom;
        logic [CB_W-1:0]   cb;
        logic [AP_W-1:0]   ap;
    } walk_res_t;

    // number of virtual address bits kept as page offset for each page type
    function automatic int page_low_bits(input int kind);
        case (kind)
            1:       return 16;
            2:       return 12;
            3:       return 10;
            default: return SEC_LO;
        endcase
    endfunction

endpackage

// File: rtl/ttw_splice.sv
module ttw_splice #(
    parameter int W  = 32,
    parameter int LO = 12
) (
    input  logic [W-1:LO] hi_i,
    input  logic [LO-1:0] lo_i,
    output logic [W-1:0]  out_o
);
    assign out_o = {hi_i, lo_i};
endmodule

// File: rtl/ttw_l1_decode.sv
module ttw_l1_decode
    import ttw_pkg::*;
(
    input  logic [WORD_W-1:COARSE_LO] base_i,
    input  logic [DOM_W-1:0]          dom_i,
    input  logic [CB_W-1:0]           cb_i,
    input  logic [1:0]                kind_i,
    input  logic [SEC_LO-1:0]         va_lo_i,
    input  logic                      fine_en_i,
    output logic                      fault_o,
    output logic                      leaf_o,
    output logic [WORD_W-1:0]         l2_addr_o,
    output walk_res_t                 res_o
);
    logic [WORD_W-1:0] sec_pa;
    logic [WORD_W-1:0] coarse_addr;
    logic [WORD_W-1:0] fine_addr;
    l1_kind_t          kind;

    assign kind = l1_kind_t'(kind_i);

    ttw_splice #(.W(WORD_W), .LO(SEC_LO)) u_sec (
        .hi_i  (base_i[WORD_W-1:SEC_LO]),
        .lo_i  (va_lo_i),
        .out_o (sec_pa)
    );

    ttw_splice #(.W(WORD_W), .LO(COARSE_LO)) u_coarse (
        .hi_i  (base_i[WORD_W-1:COARSE_LO]),
        .lo_i  ({va_lo_i[SEC_LO-1:FINE_LO], 2'b00}),
        .out_o (coarse_addr)
    );

    ttw_splice #(.W(WORD_W), .LO(FINE_LO)) u_fine (
        .hi_i  (base_i[WORD_W-1:FINE_LO]),
        .lo_i  ({va_lo_i[SEC_LO-1:COARSE_LO], 2'b00}),
        .out_o (fine_addr)
    );

    always_comb begin
        fault_o   = (kind == DK_FAULT) || ((kind == DK_FINE) && !fine_en_i);
        leaf_o    = (kind == DK_SECTION);
        l2_addr_o = (kind == DK_COARSE) ? coarse_addr : fine_addr;
        res_o     = '0;
        res_o.dom = dom_i;
        if (fault_o) begin
            res_o.fault = 1'b1;
        end else begin
            res_o.pa    = sec_pa;
            res_o.ptype = PG_SECTION;
            res_o.cb    = cb_i;
            res_o.ap    = {{(AP_W-2){1'b0}}, base_i[11:10]};
        end
    end
endmodule

// File: rtl/ttw_l2_decode.sv
module ttw_l2_decode
    import ttw_pkg::*;
(
    input  logic [WORD_W-1:0]  desc_i,
    input  logic [L2_VA_W-1:0] va_lo_i,
    input  logic [DOM_W-1:0]   dom_i,
    output walk_res_t          res_o
);
    logic [WORD_W-1:0] cand [4];

    assign cand[0] = '0;

    for (genvar g = 1; g < 4; g++) begin : g_page
        localparam int LW = page_low_bits(g);
        ttw_splice #(.W(WORD_W), .LO(LW)) u_pg (
            .hi_i  (desc_i[WORD_W-1:LW]),
            .lo_i  (va_lo_i[LW-1:0]),
            .out_o (cand[g])
        );
    end

    always_comb begin
        res_o     = '0;
        res_o.dom = dom_i;
        if (desc_i[1:0] == 2'd0) begin
            res_o.fault = 1'b1;
        end else begin
            res_o.pa    = cand[desc_i[1:0]];
            res_o.ptype = page_t'(desc_i[1:0]);
            res_o.cb    = desc_i[3:2];
            if (desc_i[1:0] == 2'd3) begin
                res_o.ap = {{(AP_W-2){1'b0}}, desc_i[5:4]};
            end else begin
                res_o.ap = desc_i[11:4];
            end
        end
    end
endmodule

// File: rtl/ttw_walker.sv
module ttw_walker
    import ttw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       va_i,
    input  logic [17:0]       tbase_i,
    input  logic              fine_en_i,
    output logic              mem_req_o,
    output logic [31:0]       mem_addr_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_o,
    output logic [31:0]       pa_o,
    output logic [1:0]        ptype_o,
    output logic [3:0]        domain_o,
    output logic [1:0]        cb_o,
    output logic [7:0]        ap_o
);
    typedef struct packed {
        walk_st_t          st;
        logic [SEC_LO-1:0] va;
        logic              fine;
        logic [DOM_W-1:0]  dom;
        logic [WORD_W-1:0] addr;
        walk_res_t         res;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [WORD_W-1:0] l1_addr;
    logic              l1_fault;
    logic              l1_leaf;
    logic [WORD_W-1:0] l2_addr;
    walk_res_t         l1_res;
    walk_res_t         l2_res;

    ttw_splice #(.W(WORD_W), .LO(TB_LO)) u_l1_addr (
        .hi_i  (tbase_i),
        .lo_i  ({va_i[WORD_W-1:SEC_LO], 2'b00}),
        .out_o (l1_addr)
    );

    ttw_l1_decode u_l1 (
        .base_i    (mem_rdata_i[WORD_W-1:COARSE_LO]),
        .dom_i     (mem_rdata_i[8:5]),
        .cb_i      (mem_rdata_i[3:2]),
        .kind_i    (mem_rdata_i[1:0]),
        .va_lo_i   (regs_q.va),
        .fine_en_i (regs_q.fine),
        .fault_o   (l1_fault),
        .leaf_o    (l1_leaf),
        .l2_addr_o (l2_addr),
        .res_o     (l1_res)
    );

    ttw_l2_decode u_l2 (
        .desc_i  (mem_rdata_i),
        .va_lo_i (regs_q.va[L2_VA_W-1:0]),
        .dom_i   (regs_q.dom),
        .res_o   (l2_res)
    );

    always_comb begin
        regs_d = regs_q;
        case (regs_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    regs_d.va   = va_i[SEC_LO-1:0];
                    regs_d.fine = fine_en_i;
                    regs_d.addr = l1_addr;
                    regs_d.st   = ST_L1;
                end
            end
            ST_L1: begin
                if (mem_ack_i) begin
                    regs_d.dom = mem_rdata_i[8:5];
                    if (l1_fault || l1_leaf) begin
                        regs_d.res = l1_res;
                        regs_d.st  = ST_DONE;
                    end else begin
                        regs_d.addr = l2_addr;
                        regs_d.st   = ST_L2;
                    end
                end
            end
            ST_L2: begin
                if (mem_ack_i) begin
                    regs_d.res = l2_res;
                    regs_d.st  = ST_DONE;
                end
            end
            default: begin
                regs_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_IDLE, default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mem_req_o  = (regs_q.st == ST_L1) || (regs_q.st == ST_L2);
    assign mem_addr_o = regs_q.addr;
    assign busy_o     = (regs_q.st != ST_IDLE);
    assign done_o     = (regs_q.st == ST_DONE);
    assign fault_o    = regs_q.res.fault;
    assign pa_o       = regs_q.res.pa;
    assign ptype_o    = regs_q.res.ptype;
    assign domain_o   = regs_q.res.dom;
    assign cb_o       = regs_q.res.cb;
    assign ap_o       = regs_q.res.ap;
endmodule

// File: rtl/ttw_walker_chk.sv
module ttw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        mem_req_o,
    input logic [31:0] mem_addr_o,
    input logic        mem_ack_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        fault_o,
    input logic [31:0] pa_o,
    input logic [1:0]  ptype_o,
    input logic [1:0]  cb_o,
    input logic [7:0]  ap_o
);
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r12_req_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (busy_o && !done_o));

    a_r12_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(mem_req_o && mem_ack_i));

    a_r2_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> (pa_o == 32'd0 && cb_o == 2'd0 && ap_o == 8'd0 && ptype_o == 2'd0));

    a_r9_tiny_ap: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o && ptype_o == 2'd3) |-> (ap_o[7:2] == 6'd0));

    a_r5_section_ap: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o && ptype_o == 2'd0) |-> (ap_o[7:2] == 6'd0));

    a_r13_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !done_o) |=> busy_o);
endmodule

bind ttw_walker ttw_walker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_ack_i  (mem_ack_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fault_o    (fault_o),
    .pa_o       (pa_o),
    .ptype_o    (ptype_o),
    .cb_o       (cb_o),
    .ap_o       (ap_o)
);

// File: tb/ttw_walker_tb_top.sv
module ttw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] va_i = '0;
    logic [17:0] tbase_i = '0;
    logic        fine_en_i = 1'b0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        busy_o, done_o, fault_o;
    logic [31:0] pa_o;
    logic [1:0]  ptype_o, cb_o;
    logic [3:0]  domain_o;
    logic [7:0]  ap_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ttw_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i),
        .tbase_i(tbase_i), .fine_en_i(fine_en_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
        .pa_o(pa_o), .ptype_o(ptype_o), .domain_o(domain_o),
        .cb_o(cb_o), .ap_o(ap_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // one walk: drives start, plays memory, checks every read and the result
    task automatic walk(input logic [31:0] va, input logic [17:0] tb, input bit fen,
                        input logic [31:0] d1, input logic [31:0] d2,
                        input int lat, input bit poke);
        logic [31:0] e_l1, e_l2, e_pa;
        logic [7:0]  e_ap;
        logic [1:0]  e_cb, e_ty, k1, k2;
        logic [3:0]  e_dom;
        bit          e_fault;
        int          e_reads, reads, wc, n;
        k1 = d1[1:0];
        k2 = d2[1:0];
        e_l1  = ({tb, 14'd0}) | ((va >> 20) << 2);
        e_dom = 4'((d1 >> 5) & 32'hF);
        e_l2 = '0; e_pa = '0; e_ap = '0; e_cb = '0; e_ty = '0; e_fault = 0;
        if (k1 == 2'd0 || (k1 == 2'd3 && !fen)) begin
            e_fault = 1; e_reads = 1;
        end else if (k1 == 2'd2) begin
            e_reads = 1;
            e_pa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
            e_cb = 2'((d1 >> 2) & 3);
            e_ap = 8'((d1 >> 10) & 3);
        end else begin
            e_reads = 2;
            if (k1 == 2'd1) e_l2 = (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
            else            e_l2 = (d1 & 32'hFFFF_F000) | (((va >> 10) & 32'h3FF) << 2);
            if (k2 == 2'd0) begin
                e_fault = 1;
            end else begin
                e_ty = k2;
                e_cb = 2'((d2 >> 2) & 3);
                case (k2)
                    2'd1: begin e_pa = (d2 & 32'hFFFF_0000) | (va & 32'hFFFF); e_ap = 8'((d2 >> 4) & 255); end
                    2'd2: begin e_pa = (d2 & 32'hFFFF_F000) | (va & 32'hFFF);  e_ap = 8'((d2 >> 4) & 255); end
                    default: begin e_pa = (d2 & 32'hFFFF_FC00) | (va & 32'h3FF); e_ap = 8'((d2 >> 4) & 3); end
                endcase
            end
        end

        @(negedge clk);
        start_i = 1; va_i = va; tbase_i = tb; fine_en_i = fen;
        @(negedge clk);
        start_i = 0;
        va_i = ~va; tbase_i = ~tb; fine_en_i = ~fen;   // inputs must have been latched
        reads = 0; wc = 0; n = 0;
        while (!done_o && n < 100) begin
            start_i = 0;
            if (mem_req_o) begin
                if (wc == lat) begin
                    mem_ack_i = 1;
                    mem_rdata_i = (reads == 0) ? d1 : d2;
                    if (reads == 0) chk(mem_addr_o == e_l1, "R1 first read address", mem_addr_o, e_l1);
                    else if (k1 == 2'd1) chk(mem_addr_o == e_l2, "R6 coarse read address", mem_addr_o, e_l2);
                    else chk(mem_addr_o == e_l2, "R7 fine read address", mem_addr_o, e_l2);
                    reads++;
                    wc = 0;
                end else begin
                    mem_ack_i = 0;
                    mem_rdata_i = 32'hDEAD_BEEF ^ 32'(n);   // R11: junk outside ack
                    if (poke && wc == 0) start_i = 1;      // R13: start while busy
                    wc++;
                end
            end else begin
                mem_ack_i = 0;
            end
            @(negedge clk);
            n++;
        end
        mem_ack_i = 0;
        start_i = 0;
        chk(done_o == 1'b1, "R12 done reached", 32'(done_o), 32'd1);
        chk(reads == e_reads, (e_reads == 1) ? "R5 single read" : "R3 second read made", 32'(reads), 32'(e_reads));
        chk(fault_o == e_fault, fen ? "R2 fault flag" : "R3 fault flag", 32'(fault_o), 32'(e_fault));
        chk(pa_o == e_pa, (e_reads == 1) ? "R5 physical address" : "R8 physical address", pa_o, e_pa);
        chk(ptype_o == e_ty, "R10 page type", 32'(ptype_o), 32'(e_ty));
        chk(domain_o == e_dom, "R4 domain", 32'(domain_o), 32'(e_dom));
        chk(cb_o == e_cb, "R9 cacheable bits", 32'(cb_o), 32'(e_cb));
        chk(ap_o == e_ap, "R9 permission field", 32'(ap_o), 32'(e_ap));
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R12 done single cycle", {busy_o, done_o}, 32'd0);
        if (poke) begin
            @(negedge clk);
            chk(mem_req_o == 1'b0 && busy_o == 1'b0, "R13 no extra walk", {mem_req_o, busy_o}, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] vas [3];
        vas[0] = 32'h1234_5678;
        vas[1] = 32'hFEDC_BA98;
        vas[2] = 32'hA5A5_3C3C;
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && mem_req_o == 0, "R12 reset idle",
            {mem_req_o, busy_o, done_o}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk(busy_o == 0 && mem_req_o == 0, "R12 idle after reset", {mem_req_o, busy_o}, 32'd0);
        for (int k1 = 0; k1 < 4; k1++) begin
            for (int fen = 0; fen < 2; fen++) begin
                for (int k2 = 0; k2 < 4; k2++) begin
                    for (int vi = 0; vi < 3; vi++) begin
                        for (int lat = 0; lat < 3; lat++) begin
                            logic [31:0] d1, d2;
                            logic [17:0] tb;
                            d1 = ((32'h9E37_79B9 * 32'(k2 * 7 + vi * 3 + lat + 1)) & 32'hFFFF_FFFC) | 32'(k1);
                            d2 = ((32'h7F4A_7C15 * 32'(k1 * 11 + fen * 5 + vi + lat + 3)) & 32'hFFFF_FFFC) | 32'(k2);
                            tb = 18'((32'h0002_B5A3 * 32'(vi + lat + k1 + 1)) & 32'h3FFFF);
                            walk(vas[vi], tb, fen[0], d1, d2, lat, (lat > 0) && (vi == 1));
                        end
                    end
                end
            end
        end
        summary();
    end
endmodule